// File: doc/BRIEF.md
# Wake-up and watchdog reset supervisor

This block sits next to a microcontroller and supervises it. It drives an active-low reset output and a periodic wake-up square wave, and it watches a watchdog input for falling edges. A synchronous "supply good" input takes the place of an analog voltage comparator. A hardware reset, or a supply that is not good, holds the controller in reset. Once the supply is good, reset is held for one more reset-delay interval before it is released.

After reset releases, the block waits a start delay and then produces wake-up cycles. Each cycle is high for half the period and low for the other half. A sleeping controller wakes on the rising edge and answers with a watchdog falling edge. The first such edge in a cycle pulls the wake-up output low for the rest of that cycle. A cycle that ends without any edge causes a reset pulse, followed by the start delay again.

All timing derives from one base unit. A prescaler produces that unit from the system clock, using the parameter `UNIT_CLKS` (clock cycles per unit). The reset pulse is 1 unit, the start delay 4 units and the wake-up period 8 units.

Top module: `wake_supervisor`

## Requirements
- R1: While the synchronous hardware reset `rst` is high, and afterwards for as long as `supplyOk` stays low, `resetN` and `wakeOut` are both 0.
- R2: When `supplyOk` is low at a rising clock edge, `resetN` and `wakeOut` are 0 after that edge, even mid-cycle. They stay 0 while `supplyOk` is low, and then for a further full reset delay.
- R3: `supplyOk` may go high before rising edge k. Then `resetN` rises after edge k + 1·UNIT_CLKS, provided `supplyOk` stays high. If `supplyOk` drops during the delay, the delay starts over.
- R4: After `resetN` rises, `wakeOut` stays 0 for 4·UNIT_CLKS clock cycles and then rises. It never rises in the same cycle as `resetN`.
- R5: With the watchdog serviced only during the low half, `wakeOut` is high for 4·UNIT_CLKS cycles and low for 4·UNIT_CLKS cycles. Its rising edges are 8·UNIT_CLKS cycles apart.
- R6: A falling edge on `wdogIn` is synchronised through two flops. If it occurs during the high half of a cycle, `wakeOut` goes low after the third rising edge following the input's fall and stays low until the next cycle starts. An edge anywhere in the cycle up to its last two cycles counts for that cycle, so no reset follows.
- R7: Only high-to-low transitions of `wdogIn` count. A rising edge has no effect. Second and later falling edges in one cycle change nothing.
- R8: A wake-up cycle with no counted falling edge ends with `resetN` going low for 1·UNIT_CLKS cycles. A new 4·UNIT_CLKS start delay then follows before `wakeOut` rises.
- R9: A falling edge during the reset pulse or the start delay does not count for the following wake-up cycle.
- R10: `wakeOut` is never 1 while `resetN` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| supplyOk | input | 1 | Supply is in regulation (synchronous) |
| wdogIn | input | 1 | Watchdog input from the controller, asynchronous |
| resetN | output | 1 | Active-low reset to the controller |
| wakeOut | output | 1 | Wake-up square wave |

## Verification
Assertions check the following on every cycle:
- the immediate reaction to a supply drop;
- that reset never releases without a good supply;
- that wake-up stays low whenever reset is active and at the moment reset releases;
- that a latched watchdog edge keeps wake-up low for the rest of its cycle;
- that the prescaler stays in range.

Only the bench's scenarios can show the interval lengths: the reset delay, the start gap, the half periods, and the restarted delay after a supply glitch. They also show that a missed cycle leads to a reset. A sweep of the watchdog edge over every offset of a cycle shows where an edge still counts and when the wake-up output drops. A cycle-level model, compared on every clock, confirms that edges arriving during the reset pulse or start delay are ignored.

// File: rtl/wake_sup_pkg.sv
package wake_sup_pkg;

  // Fixed timing ratios, in base units
  localparam int RESET_UNITS = 1;
  localparam int START_UNITS = 4;
  localparam int HALF_UNITS  = 4;
  localparam int MAX_UNITS   = (START_UNITS > HALF_UNITS) ?
                               ((START_UNITS > RESET_UNITS) ? START_UNITS : RESET_UNITS) :
                               ((HALF_UNITS > RESET_UNITS) ? HALF_UNITS : RESET_UNITS);

  typedef enum logic [2:0] {
    ST_SUPPLY_BAD = 3'd0,
    ST_RST_HOLD   = 3'd1,
    ST_START_DLY  = 3'd2,
    ST_WAKE_HI    = 3'd3,
    ST_WAKE_LO    = 3'd4
  } supState_e;

  typedef enum logic [1:0] {
    LIM_RESET = 2'd0,
    LIM_START = 2'd1,
    LIM_HALF  = 2'd2
  } limSel_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic    clrTimer;
    limSel_e limSel;
    logic    clrSeen;
    logic    armSeen;
  } supStrobe_t;

endpackage

// File: rtl/wake_sup_datapath.sv
module wake_sup_datapath
  import wake_sup_pkg::*;
#(
  parameter int UNIT_CLKS   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wdogIn,
  input  supStrobe_t strobe,
  output logic       phaseDone,
  output logic       fallPulse,
  output logic       seenEdge
);

  localparam int PRE_W  = (UNIT_CLKS > 1) ? $clog2(UNIT_CLKS) : 1;
  localparam int UNIT_W = $clog2(MAX_UNITS + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(UNIT_CLKS - 1);
  localparam logic [UNIT_W-1:0] LAST_RESET = UNIT_W'(RESET_UNITS - 1);
  localparam logic [UNIT_W-1:0] LAST_START = UNIT_W'(START_UNITS - 1);
  localparam logic [UNIT_W-1:0] LAST_HALF  = UNIT_W'(HALF_UNITS - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevSample;
  logic [PRE_W-1:0]       preCnt;
  logic [UNIT_W-1:0]      unitCnt;
  logic [UNIT_W-1:0]      unitLast;
  logic                   seenQ;

  // Watchdog synchroniser chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncQ[0] <= 1'b0;
          else     syncQ[0] <= wdogIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) syncQ[s] <= 1'b0;
          else     syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prevSample <= 1'b0;
    else     prevSample <= syncQ[SYNC_STAGES-1];
  end

  assign fallPulse = prevSample & ~syncQ[SYNC_STAGES-1];

  // Phase limit selected by control
  always_comb begin
    case (strobe.limSel)
      LIM_RESET: unitLast = LAST_RESET;
      LIM_START: unitLast = LAST_START;
      default:   unitLast = LAST_HALF;
    endcase
  end

  // Prescaler and unit counter
  always_ff @(posedge clk) begin
    if (rst || strobe.clrTimer) begin
      preCnt  <= '0;
      unitCnt <= '0;
    end else if (preCnt == PRE_LAST) begin
      preCnt  <= '0;
      unitCnt <= unitCnt + 1'b1;
    end else begin
      preCnt  <= preCnt + 1'b1;
    end
  end

  assign phaseDone = (preCnt == PRE_LAST) && (unitCnt == unitLast);

  // Watchdog-seen flag for the current wake-up cycle
  always_ff @(posedge clk) begin
    if (rst)                             seenQ <= 1'b0;
    else if (strobe.clrSeen)             seenQ <= 1'b0;
    else if (strobe.armSeen && fallPulse) seenQ <= 1'b1;
  end

  assign seenEdge = seenQ;

  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (rst)
    preCnt <= PRE_LAST); // R3

  AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (seenQ && !strobe.clrSeen) |=> seenQ); // R7

endmodule

// File: rtl/wake_sup_ctrl.sv
module wake_sup_ctrl
  import wake_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       supplyOk,
  input  logic       phaseDone,
  input  logic       fallPulse,
  input  logic       seenEdge,
  output supStrobe_t strobe,
  output logic       resetN,
  output logic       wakeOut
);

  supState_e state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_SUPPLY_BAD: if (supplyOk)  nextState = ST_RST_HOLD;
      ST_RST_HOLD:   if (phaseDone) nextState = ST_START_DLY;
      ST_START_DLY:  if (phaseDone) nextState = ST_WAKE_HI;
      ST_WAKE_HI:    if (phaseDone) nextState = ST_WAKE_LO;
      ST_WAKE_LO:    if (phaseDone) nextState = (seenEdge || fallPulse) ? ST_WAKE_HI : ST_RST_HOLD;
      default:       nextState = ST_SUPPLY_BAD;
    endcase
    if (!supplyOk) nextState = ST_SUPPLY_BAD;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_SUPPLY_BAD;
    else     state <= nextState;
  end

  always_comb begin
    strobe.clrTimer = (nextState != state) || (state == ST_SUPPLY_BAD);
    case (state)
      ST_RST_HOLD:  strobe.limSel = LIM_RESET;
      ST_START_DLY: strobe.limSel = LIM_START;
      default:      strobe.limSel = LIM_HALF;
    endcase
    strobe.clrSeen = (nextState == ST_WAKE_HI) && (state != ST_WAKE_HI);
    strobe.armSeen = (state == ST_WAKE_HI) || (state == ST_WAKE_LO);
  end

  assign resetN  = (state == ST_START_DLY) || (state == ST_WAKE_HI) || (state == ST_WAKE_LO);
  assign wakeOut = (state == ST_WAKE_HI) && !seenEdge;

  AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (rst)
    !supplyOk |=> (!resetN && !wakeOut)); // R2

  AST_EDGE_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAKE_HI && seenEdge) |=> !wakeOut); // R6

  AST_WAKE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    wakeOut |-> resetN); // R10

endmodule

// File: rtl/wake_supervisor.sv
module wake_supervisor
  import wake_sup_pkg::*;
#(
  parameter int UNIT_CLKS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic supplyOk,
  input  logic wdogIn,
  output logic resetN,
  output logic wakeOut
);

  supStrobe_t strobe;
  logic       phaseDone;
  logic       fallPulse;
  logic       seenEdge;

  wake_sup_datapath #(.UNIT_CLKS(UNIT_CLKS), .SYNC_STAGES(2)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .wdogIn    (wdogIn),
    .strobe    (strobe),
    .phaseDone (phaseDone),
    .fallPulse (fallPulse),
    .seenEdge  (seenEdge)
  );

  wake_sup_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .supplyOk  (supplyOk),
    .phaseDone (phaseDone),
    .fallPulse (fallPulse),
    .seenEdge  (seenEdge),
    .strobe    (strobe),
    .resetN    (resetN),
    .wakeOut   (wakeOut)
  );

  AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    $rose(resetN) |-> $past(supplyOk)); // R3

  AST_START_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(resetN) |-> !wakeOut); // R4

  AST_WAKE_RISE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(wakeOut) |-> $past(resetN)); // R4

endmodule

// File: tb/wake_supervisor_tb_top.sv
`timescale 1ns/1ps
module wake_supervisor_tb_top;

  localparam int U    = 3;
  localparam int HALF = 4 * U;
  localparam int PER  = 8 * U;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supplyOk = 1'b0;
  logic wdogIn = 1'b1;
  logic resetN, wakeOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wake_supervisor #(.UNIT_CLKS(U)) dut_i (
    .clk(clk), .rst(rst), .supplyOk(supplyOk), .wdogIn(wdogIn),
    .resetN(resetN), .wakeOut(wakeOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Cycle-level reference: one countdown per mode
  int  mMode = 0;   // 0 bad,1 hold,2 start,3 hi,4 lo
  int  mCnt  = 0;
  bit  mSeen = 0;
  bit  m1 = 0, m2 = 0, m3 = 0;
  bit  fallM;

  always @(posedge clk) begin
    fallM = m3 & ~m2;
    if (rst) begin
      mMode = 0; mCnt = 0; mSeen = 0; m1 = 0; m2 = 0; m3 = 0;
    end else begin
      m3 = m2; m2 = m1; m1 = wdogIn;
      if (!supplyOk) mMode = 0;
      else begin
        case (mMode)
          0: begin mMode = 1; mCnt = U - 1; end
          1: if (mCnt == 0) begin mMode = 2; mCnt = HALF - 1; end else mCnt--;
          2: if (mCnt == 0) begin mMode = 3; mCnt = HALF - 1; mSeen = 0; end else mCnt--;
          3: begin
               if (fallM) mSeen = 1;
               if (mCnt == 0) begin mMode = 4; mCnt = HALF - 1; end else mCnt--;
             end
          default: begin
               if (mCnt == 0) begin
                 if (mSeen || fallM) begin mMode = 3; mCnt = HALF - 1; mSeen = 0; end
                 else begin mMode = 1; mCnt = U - 1; end
               end else begin
                 if (fallM) mSeen = 1;
                 mCnt--;
               end
             end
        endcase
      end
    end
  end

  // Per-cycle comparison and output monitor
  bit    cmpOn = 0;
  int    cyc = 0, riseCyc = 0, riseCount = 0, lastHigh = 0, lastPeriod = 0;
  bit    prevWake = 0, rstSeen = 0;
  string tag;

  always @(negedge clk) begin
    cyc++;
    if (cmpOn) begin
      case (mMode)
        0: tag = "R2";
        1: tag = "R3";
        2: tag = "R4";
        default: tag = "R5";
      endcase
      check(resetN == ((mMode >= 2) ? 1'b1 : 1'b0), {tag, " resetN"}, resetN, (mMode >= 2));
      check(wakeOut == ((mMode == 3 && !mSeen) ? 1'b1 : 1'b0), {tag, " wakeOut"},
            wakeOut, (mMode == 3 && !mSeen));
      check(!(wakeOut && !resetN), "R10 wake while reset", wakeOut, 0);
    end
    if (wakeOut && !prevWake) begin
      lastPeriod = cyc - riseCyc;
      riseCyc = cyc;
      riseCount++;
    end
    if (!wakeOut && prevWake) lastHigh = cyc - riseCyc;
    if (!resetN) rstSeen = 1;
    prevWake = wakeOut;
  end

  int wdCyc = 0;
  always @(posedge clk) begin
    wdCyc++;
    if (wdCyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", wdCyc, 150000);
      finishRun();
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic countWhile(input bit useWake, input bit level, output int n);
    n = 0;
    while (((useWake ? wakeOut : resetN) == level) && n < 1000) begin
      n++;
      step();
    end
  endtask

  task automatic waitRise(input int startCount);
    int g = 0;
    while (riseCount == startCount && g < 200) begin
      g++;
      step();
    end
  endtask

  initial begin
    int n;
    int expHigh;
    int startCount;
    repeat (3) step();
    cmpOn = 1;
    check(resetN == 0, "R1 resetN in hw reset", resetN, 0);
    check(wakeOut == 0, "R1 wakeOut in hw reset", wakeOut, 0);
    rst = 0;
    repeat (20) step();
    check(resetN == 0 && wakeOut == 0, "R1 held while supply bad", resetN, 0);

    // Power-up sequence with a silent first cycle
    supplyOk = 1;
    step();
    countWhile(0, 0, n); check(n == U, "R3 reset delay", n, U);
    countWhile(1, 0, n); check(n == HALF, "R4 start gap", n, HALF);
    countWhile(1, 1, n); check(n == HALF, "R5 high half", n, HALF);
    countWhile(0, 1, n); check(n == HALF, "R5 low half", n, HALF);
    countWhile(0, 0, n); check(n == U, "R8 reset pulse", n, U);
    countWhile(1, 0, n); check(n == HALF, "R8 restart delay", n, HALF);

    // Sweep of watchdog edge offset within a cycle
    for (int k = 0; k <= PER - 3; k++) begin
      startCount = riseCount;
      rstSeen = 0;
      repeat (k) step();
      wdogIn = 0;
      step();
      wdogIn = 1;
      waitRise(startCount);
      expHigh = (k + 3 < HALF) ? k + 3 : HALF;
      check(lastHigh == expHigh, "R6 high width", lastHigh, expHigh);
      check(lastPeriod == PER, "R5 period", lastPeriod, PER);
      check(rstSeen == 0, "R6 no reset", rstSeen, 0);
    end

    // Repeated edges in one cycle
    startCount = riseCount;
    rstSeen = 0;
    step(); wdogIn = 0; step(); wdogIn = 1;
    repeat (4) step(); wdogIn = 0; step(); wdogIn = 1;
    repeat (HALF) step(); wdogIn = 0; step(); wdogIn = 1;
    waitRise(startCount);
    check(lastHigh == 4, "R7 extra edges ignored", lastHigh, 4);
    check(rstSeen == 0 && lastPeriod == PER, "R7 cycle intact", lastPeriod, PER);

    // Edges only during reset pulse and start delay, plus a rising edge in the cycle
    countWhile(0, 1, n);
    step(); wdogIn = 0; step(); wdogIn = 1;
    countWhile(0, 0, n);
    step(); wdogIn = 0; step(); wdogIn = 1;
    repeat (3) step(); wdogIn = 0;
    countWhile(1, 0, n);
    step(); step(); wdogIn = 1;
    countWhile(1, 1, n);
    check(lastHigh == HALF, "R9 early edges ignored", lastHigh, HALF);
    countWhile(0, 1, n); check(n == HALF, "R7 rising edge ignored", n, HALF);
    countWhile(0, 0, n); check(n == U, "R9 reset after silent cycle", n, U);

    // Supply drop mid-cycle, then a glitch during the reset delay
    countWhile(1, 0, n);
    step(); step();
    supplyOk = 0;
    step();
    check(resetN == 0 && wakeOut == 0, "R2 immediate drop", resetN, 0);
    repeat (10) step();
    check(resetN == 0, "R2 held while supply bad", resetN, 0);
    supplyOk = 1;
    step();
    supplyOk = 0;
    step();
    supplyOk = 1;
    step();
    countWhile(0, 0, n); check(n == U, "R2 delay restarts", n, U);
    countWhile(1, 0, n); check(n == HALF, "R4 start gap again", n, HALF);
    repeat (5) step();
    finishRun();
  end

endmodule